// File: doc/BRIEF.md
# Memory Reference Classifier and Bus Transfer Monitor

This block sits at the front of a cache model. It takes a stream of memory reference records, each a 3-bit label and an address. It sorts each record into a data read, a data write, an instruction fetch, an unknown access or a flush command, and forwards the class with the address one cycle later. A configurable number of leading references is discarded. After that, a reference budget caps how many are forwarded. A periodic flush pulse can be raised after every N forwarded demand references.

Alongside, it watches the bus transfers the cache issues: read, write, prefetch and snoop. For each accepted transfer it emits a record holding the transfer kind, size and address. The record also carries two counts covering the interval since the previous emitted record: forwarded demand references and forwarded instruction fetches. Transfers arrive on the bus port and never enter the counts, so prefetches generated by the cache are excluded. Snoop records are passed only when the extended monitoring mode is enabled.

Top module: `ref_stream_monitor`

## Requirements
- R1: A forwarded reference with label 0, 1 or 2 appears one cycle later on `out_valid` with `out_kind` 0 (data read), 1 (data write) or 2 (instruction fetch), and its address on `out_addr`.
- R2: Labels 3, 5, 6 and 7 are forwarded with `out_kind` 3 (unknown access).
- R3: Label 4 is forwarded with `out_kind` 4 (flush command).
- R4: The first `cfg_skip` references after reset produce no output and are not counted anywhere.
- R5: After the skipped ones, at most `cfg_limit` references are forwarded. Once that many have been forwarded, `done` is high and later references produce no output.
- R6: An accepted bus transfer yields `tr_valid` one cycle later, with `tr_kind` (0 read, 1 write, 2 prefetch, 3 snoop), `tr_size` and `tr_addr` copied from the bus.
- R7: `tr_refs` gives the number of forwarded references with label 0, 1 or 2 since the previous emitted transfer. `tr_fetches` gives the number of those with label 2. Escape labels and skipped or over-budget references do not count.
- R8: Both interval counts restart in the cycle a transfer is accepted. A demand reference forwarded in that same cycle counts toward the next interval.
- R9: With `cfg_flush_every` = N > 0, `pflush` pulses together with the output of every N-th forwarded demand reference. With N = 0, `pflush` stays low.
- R10: A snoop transfer (bus kind 3) is dropped when `cfg_snoop_en` is low. It then emits no record and leaves the interval counts running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_skip | input | 32 | Number of leading references to discard |
| cfg_limit | input | 32 | Reference budget after the skip phase |
| cfg_flush_every | input | 32 | Periodic flush interval in demand references, 0 = off |
| cfg_snoop_en | input | 1 | Pass snoop transfers |
| ref_valid | input | 1 | Reference record present |
| ref_label | input | 3 | Reference label |
| ref_addr | input | 32 | Reference byte address |
| bus_valid | input | 1 | Bus transfer present |
| bus_kind | input | 2 | Transfer kind: 0 read, 1 write, 2 prefetch, 3 snoop |
| bus_size | input | 16 | Transfer size in bytes |
| bus_addr | input | 32 | Transfer byte address |
| out_valid | output | 1 | Classified reference valid |
| out_kind | output | 3 | Class: 0 read, 1 write, 2 fetch, 3 unknown, 4 flush |
| out_addr | output | 32 | Address of the classified reference |
| pflush | output | 1 | Periodic flush pulse |
| done | output | 1 | Reference budget used up |
| tr_valid | output | 1 | Transfer record valid |
| tr_kind | output | 2 | Transfer record kind |
| tr_size | output | 16 | Transfer record size |
| tr_addr | output | 32 | Transfer record address |
| tr_refs | output | 32 | Demand references in the interval |
| tr_fetches | output | 32 | Instruction fetches in the interval |

## Verification
Every result lands exactly one clock after its stimulus: classified references, `pflush` and transfer records each pass through one register stage. `done` reflects the counters as soon as the last budgeted reference is registered. The bench applies one stimulus per cycle on the falling edge, releases it, and compares the outputs at the next falling edge, half a period after the registering edge. Same-cycle coincidences of a transfer and a reference are driven together in one step, which makes the interval hand-over of R8 visible in the record that follows.

// File: rtl/refmon_pkg.sv
package refmon_pkg;

    typedef enum logic [2:0] {
        K_READ    = 3'd0,
        K_WRITE   = 3'd1,
        K_FETCH   = 3'd2,
        K_UNKNOWN = 3'd3,
        K_FLUSH   = 3'd4
    } ref_kind_e;

    typedef enum logic [1:0] {
        X_READ     = 2'd0,
        X_WRITE    = 2'd1,
        X_PREFETCH = 2'd2,
        X_SNOOP    = 2'd3
    } xfer_kind_e;

endpackage

// File: rtl/ref_decode.sv
module ref_decode
    import refmon_pkg::*;
(
    input  logic [2:0] label,
    output ref_kind_e  kind,
    output logic       is_demand,
    output logic       is_fetch
);
    always_comb begin
        is_demand = 1'b0;
        is_fetch  = 1'b0;
        case (label)
            3'd0: begin kind = K_READ;  is_demand = 1'b1; end
            3'd1: begin kind = K_WRITE; is_demand = 1'b1; end
            3'd2: begin kind = K_FETCH; is_demand = 1'b1; is_fetch = 1'b1; end
            3'd4: kind = K_FLUSH;
            default: kind = K_UNKNOWN;   // escape 3 and reserved 5..7
        endcase
    end
endmodule

// File: rtl/ref_gate.sv
module ref_gate #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_demand,
    input  logic [CW-1:0] cfg_skip,
    input  logic [CW-1:0] cfg_limit,
    input  logic [CW-1:0] cfg_flush_every,
    output logic          pass,
    output logic          pflush,
    output logic          done
);
    typedef struct packed {
        logic [CW-1:0] skipped;
        logic [CW-1:0] taken;
        logic [CW-1:0] flcnt;
        logic          pflush;
    } gate_s;

    gate_s s_d, s_q;
    logic  skip_phase;
    logic  budget_left;

    assign skip_phase  = s_q.skipped < cfg_skip;
    assign budget_left = s_q.taken < cfg_limit;

    always_comb begin
        s_d        = s_q;
        s_d.pflush = 1'b0;
        pass       = 1'b0;
        if (in_valid) begin
            if (skip_phase) begin
                s_d.skipped = s_q.skipped + CW'(1);
            end else if (budget_left) begin
                pass      = 1'b1;
                s_d.taken = s_q.taken + CW'(1);
                if (in_demand && cfg_flush_every != '0) begin
                    if (s_q.flcnt == cfg_flush_every - CW'(1)) begin
                        s_d.flcnt  = '0;
                        s_d.pflush = 1'b1;
                    end else begin
                        s_d.flcnt = s_q.flcnt + CW'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pflush = s_q.pflush;
    assign done   = !skip_phase && !budget_left;
endmodule

// File: rtl/xfer_tracker.sv
module xfer_tracker
    import refmon_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_snoop_en,
    input  logic          bus_valid,
    input  logic [1:0]    bus_kind,
    input  logic [SW-1:0] bus_size,
    input  logic [AW-1:0] bus_addr,
    input  logic          cnt_demand,
    input  logic          cnt_fetch,
    output logic          tr_valid,
    output logic [1:0]    tr_kind,
    output logic [SW-1:0] tr_size,
    output logic [AW-1:0] tr_addr,
    output logic [CW-1:0] tr_refs,
    output logic [CW-1:0] tr_fetches
);
    typedef struct packed {
        logic          valid;
        xfer_kind_e    kind;
        logic [SW-1:0] size;
        logic [AW-1:0] addr;
        logic [CW-1:0] refs;
        logic [CW-1:0] fetches;
        logic [CW-1:0] cur_refs;
        logic [CW-1:0] cur_fetches;
    } trk_s;

    trk_s       t_d, t_q;
    xfer_kind_e in_kind;
    logic       accept;

    assign in_kind = xfer_kind_e'(bus_kind);
    assign accept  = bus_valid && (in_kind != X_SNOOP || cfg_snoop_en);

    always_comb begin
        t_d       = t_q;
        t_d.valid = accept;
        if (accept) begin
            t_d.kind        = in_kind;
            t_d.size        = bus_size;
            t_d.addr        = bus_addr;
            t_d.refs        = t_q.cur_refs;
            t_d.fetches     = t_q.cur_fetches;
            t_d.cur_refs    = CW'(cnt_demand);
            t_d.cur_fetches = CW'(cnt_fetch);
        end else begin
            t_d.cur_refs    = t_q.cur_refs + CW'(cnt_demand);
            t_d.cur_fetches = t_q.cur_fetches + CW'(cnt_fetch);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign tr_valid   = t_q.valid;
    assign tr_kind    = t_q.kind;
    assign tr_size    = t_q.size;
    assign tr_addr    = t_q.addr;
    assign tr_refs    = t_q.refs;
    assign tr_fetches = t_q.fetches;
endmodule

// File: rtl/ref_stream_monitor.sv
module ref_stream_monitor
    import refmon_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 32,
    parameter int SW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_skip,
    input  logic [CW-1:0] cfg_limit,
    input  logic [CW-1:0] cfg_flush_every,
    input  logic          cfg_snoop_en,
    input  logic          ref_valid,
    input  logic [2:0]    ref_label,
    input  logic [AW-1:0] ref_addr,
    input  logic          bus_valid,
    input  logic [1:0]    bus_kind,
    input  logic [SW-1:0] bus_size,
    input  logic [AW-1:0] bus_addr,
    output logic          out_valid,
    output logic [2:0]    out_kind,
    output logic [AW-1:0] out_addr,
    output logic          pflush,
    output logic          done,
    output logic          tr_valid,
    output logic [1:0]    tr_kind,
    output logic [SW-1:0] tr_size,
    output logic [AW-1:0] tr_addr,
    output logic [CW-1:0] tr_refs,
    output logic [CW-1:0] tr_fetches
);
    typedef struct packed {
        logic          valid;
        ref_kind_e     kind;
        logic [AW-1:0] addr;
    } out_s;

    ref_kind_e dec_kind;
    logic      dec_demand;
    logic      dec_fetch;
    logic      fwd;
    out_s      o_d, o_q;

    ref_decode u_dec (
        .label     (ref_label),
        .kind      (dec_kind),
        .is_demand (dec_demand),
        .is_fetch  (dec_fetch)
    );

    ref_gate #(.CW(CW)) u_gate (
        .clk             (clk),
        .rst_n           (rst_n),
        .in_valid        (ref_valid),
        .in_demand       (dec_demand),
        .cfg_skip        (cfg_skip),
        .cfg_limit       (cfg_limit),
        .cfg_flush_every (cfg_flush_every),
        .pass            (fwd),
        .pflush          (pflush),
        .done            (done)
    );

    xfer_tracker #(.AW(AW), .CW(CW), .SW(SW)) u_trk (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_snoop_en (cfg_snoop_en),
        .bus_valid    (bus_valid),
        .bus_kind     (bus_kind),
        .bus_size     (bus_size),
        .bus_addr     (bus_addr),
        .cnt_demand   (fwd && dec_demand),
        .cnt_fetch    (fwd && dec_fetch),
        .tr_valid     (tr_valid),
        .tr_kind      (tr_kind),
        .tr_size      (tr_size),
        .tr_addr      (tr_addr),
        .tr_refs      (tr_refs),
        .tr_fetches   (tr_fetches)
    );

    always_comb begin
        o_d       = o_q;
        o_d.valid = fwd;
        if (fwd) begin
            o_d.kind = dec_kind;
            o_d.addr = ref_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign out_valid = o_q.valid;
    assign out_kind  = o_q.kind;
    assign out_addr  = o_q.addr;
endmodule

// File: rtl/refmon_checker.sv
module refmon_checker #(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_snoop_en,
    input logic          ref_label_b0,
    input logic [2:0]    ref_label,
    input logic [AW-1:0] ref_addr,
    input logic          fwd,
    input logic          bus_valid,
    input logic [1:0]    bus_kind,
    input logic          out_valid,
    input logic [2:0]    out_kind,
    input logic [AW-1:0] out_addr,
    input logic          pflush,
    input logic          done,
    input logic          tr_valid,
    input logic [CW-1:0] tr_refs,
    input logic [CW-1:0] tr_fetches
);
    a_r1_forward: assert property (@(posedge clk) disable iff (!rst_n)
        fwd |=> (out_valid && out_addr == $past(ref_addr)));

    a_r2_unknown: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd && ref_label != 3'd4 && ref_label > 3'd2) |=> out_kind == 3'd3);

    a_r3_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd && ref_label == 3'd4) |=> out_kind == 3'd4);

    a_r5_budget_stop: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !out_valid);

    a_r6_record: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_kind != 2'd3) |=> tr_valid);

    a_r7_fetch_subset: assert property (@(posedge clk) disable iff (!rst_n)
        tr_valid |-> tr_fetches <= tr_refs);

    a_r9_pflush_with_ref: assert property (@(posedge clk) disable iff (!rst_n)
        pflush |-> (out_valid && out_kind <= 3'd2));

    a_r10_snoop_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_kind == 2'd3 && !cfg_snoop_en) |=> !tr_valid);

    logic unused_b0;
    assign unused_b0 = ref_label_b0;
endmodule

bind ref_stream_monitor refmon_checker #(.AW(AW), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_snoop_en (cfg_snoop_en),
    .ref_label_b0 (ref_label[0]),
    .ref_label    (ref_label),
    .ref_addr     (ref_addr),
    .fwd          (fwd),
    .bus_valid    (bus_valid),
    .bus_kind     (bus_kind),
    .out_valid    (out_valid),
    .out_kind     (out_kind),
    .out_addr     (out_addr),
    .pflush       (pflush),
    .done         (done),
    .tr_valid     (tr_valid),
    .tr_refs      (tr_refs),
    .tr_fetches   (tr_fetches)
);

// File: tb/ref_stream_monitor_tb_top.sv
module ref_stream_monitor_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg_skip, cfg_limit, cfg_flush_every;
    logic        cfg_snoop_en;
    logic        ref_valid;
    logic [2:0]  ref_label;
    logic [31:0] ref_addr;
    logic        bus_valid;
    logic [1:0]  bus_kind;
    logic [15:0] bus_size;
    logic [31:0] bus_addr;
    logic        out_valid;
    logic [2:0]  out_kind;
    logic [31:0] out_addr;
    logic        pflush, done;
    logic        tr_valid;
    logic [1:0]  tr_kind;
    logic [15:0] tr_size;
    logic [31:0] tr_addr, tr_refs, tr_fetches;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ref_stream_monitor dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_skip(cfg_skip), .cfg_limit(cfg_limit),
        .cfg_flush_every(cfg_flush_every), .cfg_snoop_en(cfg_snoop_en),
        .ref_valid(ref_valid), .ref_label(ref_label), .ref_addr(ref_addr),
        .bus_valid(bus_valid), .bus_kind(bus_kind), .bus_size(bus_size),
        .bus_addr(bus_addr),
        .out_valid(out_valid), .out_kind(out_kind), .out_addr(out_addr),
        .pflush(pflush), .done(done),
        .tr_valid(tr_valid), .tr_kind(tr_kind), .tr_size(tr_size),
        .tr_addr(tr_addr), .tr_refs(tr_refs), .tr_fetches(tr_fetches)
    );

    // {label, address, expected class}
    localparam logic [37:0] VEC [12] = '{
        {3'd0, 32'h0000_1000, 3'd0},
        {3'd1, 32'h0000_2004, 3'd1},
        {3'd2, 32'h0040_0000, 3'd2},
        {3'd3, 32'hDEAD_BEEF, 3'd3},
        {3'd4, 32'h0000_0000, 3'd4},
        {3'd5, 32'h1234_5678, 3'd3},
        {3'd6, 32'hFFFF_FFFF, 3'd3},
        {3'd7, 32'h8000_0001, 3'd3},
        {3'd2, 32'h0040_0004, 3'd2},
        {3'd0, 32'hFFFF_FFFC, 3'd0},
        {3'd1, 32'h0000_0010, 3'd1},
        {3'd4, 32'h0000_0040, 3'd4}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ref_valid = 0; ref_label = 0; ref_addr = 0;
        bus_valid = 0; bus_kind = 0; bus_size = 0; bus_addr = 0;
    endtask

    task automatic do_reset(input logic [31:0] skip, input logic [31:0] limit,
                            input logic [31:0] fl, input logic snp);
        rst_n = 0;
        cfg_skip = skip; cfg_limit = limit; cfg_flush_every = fl; cfg_snoop_en = snp;
        idle_inputs();
        @(negedge clk); @(negedge clk);
        rst_n = 1;
    endtask

    // one stimulus cycle; results are visible on return
    task automatic step(input logic rv, input logic [2:0] lb, input logic [31:0] ra,
                        input logic bv, input logic [1:0] bk, input logic [15:0] bs,
                        input logic [31:0] ba);
        ref_valid = rv; ref_label = lb; ref_addr = ra;
        bus_valid = bv; bus_kind = bk; bus_size = bs; bus_addr = ba;
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset(32'd0, 32'd1000, 32'd0, 1'b0);
        // reset state
        chk(!out_valid, "R1 reset out_valid", 32'(out_valid), 0);
        chk(!tr_valid, "R6 reset tr_valid", 32'(tr_valid), 0);
        chk(!pflush, "R9 reset pflush", 32'(pflush), 0);
        chk(!done, "R5 reset done", 32'(done), 0);

        // table walk: classification R1 R2 R3
        for (int i = 0; i < 12; i++) begin
            logic [2:0]  lb;
            logic [31:0] ad;
            logic [2:0]  ex;
            string       tag;
            {lb, ad, ex} = VEC[i];
            tag = (ex <= 3'd2) ? "R1" : (ex == 3'd3) ? "R2" : "R3";
            step(1, lb, ad, 0, 0, 0, 0);
            chk(out_valid, {tag, " valid"}, 32'(out_valid), 1);
            chk(out_kind == ex, {tag, " class"}, 32'(out_kind), 32'(ex));
            chk(out_addr == ad, {tag, " addr"}, out_addr, ad);
            chk(!pflush, "R9 flush off", 32'(pflush), 0);
        end
        step(0, 0, 0, 0, 0, 0, 0);
        chk(!out_valid, "R1 idle", 32'(out_valid), 0);

        // R6 R7: six demand refs, two fetches in the table
        step(1, 3'd2, 32'h0050_0000, 1, 2'd0, 16'd32, 32'hABCD_0000);
        chk(tr_valid, "R6 record valid", 32'(tr_valid), 1);
        chk(tr_kind == 2'd0, "R6 kind", 32'(tr_kind), 0);
        chk(tr_size == 16'd32, "R6 size", 32'(tr_size), 32);
        chk(tr_addr == 32'hABCD_0000, "R6 addr", tr_addr, 32'hABCD_0000);
        chk(tr_refs == 6, "R7 refs", tr_refs, 6);
        chk(tr_fetches == 2, "R7 fetches", tr_fetches, 2);
        // R8: same-cycle fetch went into the next interval
        step(1, 3'd3, 32'h0, 1, 2'd1, 16'd4, 32'h0000_0100);
        chk(tr_kind == 2'd1, "R6 write kind", 32'(tr_kind), 1);
        chk(tr_refs == 1, "R8 refs carry", tr_refs, 1);
        chk(tr_fetches == 1, "R8 fetches carry", tr_fetches, 1);
        // escape in previous step not counted
        step(0, 0, 0, 1, 2'd2, 16'd16, 32'h0000_0200);
        chk(tr_kind == 2'd2, "R6 prefetch kind", 32'(tr_kind), 2);
        chk(tr_refs == 0, "R7 escape not counted", tr_refs, 0);

        // R10: snoop dropped while disabled, counts keep running
        step(1, 3'd2, 32'h0000_0300, 0, 0, 0, 0);
        step(1, 3'd0, 32'h0000_0304, 1, 2'd3, 16'd8, 32'h0000_0400);
        chk(!tr_valid, "R10 snoop dropped", 32'(tr_valid), 0);
        step(0, 0, 0, 1, 2'd2, 16'd8, 32'h0000_0500);
        chk(tr_refs == 2, "R10 counts kept", tr_refs, 2);
        chk(tr_fetches == 1, "R10 fetches kept", tr_fetches, 1);

        do_reset(32'd0, 32'd1000, 32'd0, 1'b1);
        step(0, 0, 0, 1, 2'd3, 16'd8, 32'h0000_0600);
        chk(tr_valid, "R10 snoop passed", 32'(tr_valid), 1);
        chk(tr_kind == 2'd3, "R10 snoop kind", 32'(tr_kind), 3);

        // R4 R5: skip two, forward three
        do_reset(32'd2, 32'd3, 32'd0, 1'b0);
        for (int i = 1; i <= 6; i++) begin
            chk(done == (i > 5), "R5 done", 32'(done), 32'(i > 5));
            step(1, 3'd0, 32'(i), 0, 0, 0, 0);
            if (i <= 2)
                chk(!out_valid, "R4 skipped", 32'(out_valid), 0);
            else if (i <= 5)
                chk(out_valid && out_addr == 32'(i), "R5 forwarded", out_addr, 32'(i));
            else
                chk(!out_valid, "R5 over budget", 32'(out_valid), 0);
        end
        chk(done, "R5 done held", 32'(done), 1);
        step(0, 0, 0, 1, 2'd0, 16'd4, 32'h0);
        chk(tr_refs == 3, "R7 skipped not counted", tr_refs, 3);

        // R9: flush every third demand ref; escape ignored
        do_reset(32'd0, 32'd1000, 32'd3, 1'b0);
        begin
            logic [2:0] seq [8] = '{3'd0, 3'd1, 3'd3, 3'd2, 3'd0, 3'd4, 3'd1, 3'd2};
            int dem = 0;
            for (int i = 0; i < 8; i++) begin
                bit exp;
                if (seq[i] <= 3'd2) dem++;
                exp = (seq[i] <= 3'd2) && (dem % 3 == 0);
                step(1, seq[i], 32'(i), 0, 0, 0, 0);
                chk(pflush == exp, "R9 periodic flush", 32'(pflush), 32'(exp));
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule